// File: doc/BRIEF.md
# Camera Trigger Sequencer

This block is a trigger sequencer for an image sensor. It runs on the pixel clock and is set up through a small register write port. A per-pin match rule is applied to a bus of general-purpose inputs. When the combined rule becomes true, a delay countdown starts. At the end of the countdown the block issues a one-cycle trigger strobe to the sensor. If no pin takes part in the rule, the block's own output pulse generator acts as the trigger source instead.

The same block drives a timing pulse onto selected general-purpose pins. It can send that pulse once, or repeat it with a programmable period. Each pin chooses active-high, active-low, or not driven. The pulse width is a multiple of a programmable bit time.

Every per-pin field is two bits wide, and pin i sits at data bits [2i+1:2i]. The register addresses are 0 for the condition, 1 for the delay, 2 for the output select, 3 for the period and 4 for the bit length.

Top module: `cam_trig_seq`

## Requirements
- R1: After reset sensorTrig is 0, every gpioOe bit is 0, every gpioOut bit is 0, and no pulse or strobe appears while the period register holds its reset value of 0.
- R2: Condition register (address 0) codes per pin: 11 means the pin matches when high, 10 means it matches when low, and 00 means the pin is left out. Inputs pass through a two-stage synchronizer. A trigger event is the rising edge of the AND of all enabled matches, so a level that stays true fires only once.
- R3: A field code of 01 leaves that pin's stored mode unchanged, in both the condition register and the output select register, while the other fields of the same write take effect.
- R4: When every stored condition field is 00, each start of an output pulse is the trigger event.
- R5: With delay register (address 1) value D, sensorTrig is high for exactly one cycle, D cycles after the clock edge that takes the event. For a pin change that is present before clock edge c+1, this is D+3 cycles after edge c. D=0 gives the strobe right after the event edge.
- R6: A trigger event that comes while a delay countdown is running is dropped and produces no strobe.
- R7: Output select register (address 2) codes per pin: 11 means gpioOe=1 and gpioOut follows the pulse, 10 means gpioOe=1 and gpioOut is the inverted pulse, and 00 means gpioOe=0 and gpioOut=0.
- R8: Writing 1 to the period register (address 3) starts one pulse in the cycle after the write. Writing 1 again while that pulse is still high does not start another pulse.
- R9: Writing a period P of 256 or more starts a pulse in the cycle after the write, and then one every P cycles. Writing the period again restarts this count from the new write.
- R10: A period of 0, or of 2 to 255, stops generation, and no new pulse starts after it is written.
- R11: With bit-length register (address 4) value N, each output pulse lasts 8*(N+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| gpioIn | input | 10 | General-purpose pin inputs (asynchronous) |
| gpioOut | output | 10 | General-purpose pin output values |
| gpioOe | output | 10 | General-purpose pin output enables |
| sensorTrig | output | 1 | One-cycle trigger strobe to the sensor |

## Verification
The assertions assume that the bit-length register holds at least 0, so every pulse is at least 8 cycles long. They also assume that two GPIO trigger events are never on adjacent edges, because a falling match has to be synchronized in between. The stimulus only changes inputs on the falling edge. It keeps pin changes at least two cycles apart and uses only legal bit lengths. It writes repeating periods of at least 256, so a strobe can never follow another strobe directly. The scoreboard predicts each strobe cycle from the delay value and the three-edge input path.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_KEEP = 2'b01,
    MODE_LOW  = 2'b10,
    MODE_HIGH = 2'b11
  } pinMode_t;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_COND   = 3'd0;
  localparam logic [ADDR_W-1:0] REG_DELAY  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_OUTSEL = 3'd2;
  localparam logic [ADDR_W-1:0] REG_PERIOD = 3'd3;
  localparam logic [ADDR_W-1:0] REG_BITLEN = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic pulseOn;
    logic trigStrobe;
  } ctrlStrobe_t;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_seq_pkg::*;
#(
  parameter int PINS        = 10,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int BL_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [PINS-1:0]   gpioIn,
  input  ctrlStrobe_t       strb,
  output logic [PINS-1:0]   gpioOut,
  output logic [PINS-1:0]   gpioOe,
  output logic              sensorTrig,
  output logic              condLevel,
  output logic              useInternal,
  output logic [CNT_W-1:0]  delayVal,
  output logic [CNT_W-1:0]  periodVal,
  output logic [BL_W-1:0]   bitLenVal,
  output logic              periodWr
);

  localparam int FIELD_W = 2 * PINS;
  localparam logic [BL_W-1:0] BL_RESET = BL_W'(2);

  logic [PINS-1:0][1:0] condMode;
  logic [PINS-1:0][1:0] outMode;
  logic [PINS-1:0]      pinSync;
  logic [PINS-1:0][1:0] wrField;

  assign wrField = regWdata[FIELD_W-1:0];

  wire condWr = regWe && (regAddr == REG_COND);
  wire outWr  = regWe && (regAddr == REG_OUTSEL);

  // mode fields, code 01 keeps the stored mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      condMode <= '0;
      outMode  <= '0;
    end else begin
      for (int i = 0; i < PINS; i++) begin
        if (condWr && wrField[i] != MODE_KEEP) condMode[i] <= wrField[i];
        if (outWr  && wrField[i] != MODE_KEEP) outMode[i]  <= wrField[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayVal  <= '0;
      periodVal <= '0;
      bitLenVal <= BL_RESET;
      periodWr  <= 1'b0;
    end else begin
      periodWr <= regWe && (regAddr == REG_PERIOD);
      if (regWe && regAddr == REG_DELAY)  delayVal  <= regWdata[CNT_W-1:0];
      if (regWe && regAddr == REG_PERIOD) periodVal <= regWdata[CNT_W-1:0];
      if (regWe && regAddr == REG_BITLEN) bitLenVal <= regWdata[BL_W-1:0];
    end
  end

  trig_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (gpioIn),
    .dout (pinSync)
  );

  // AND of all enabled per-pin matches
  always_comb begin
    logic lvl;
    logic anyEn;
    lvl   = 1'b1;
    anyEn = 1'b0;
    for (int i = 0; i < PINS; i++) begin
      unique case (condMode[i])
        MODE_HIGH: begin lvl = lvl & pinSync[i];  anyEn = 1'b1; end
        MODE_LOW:  begin lvl = lvl & ~pinSync[i]; anyEn = 1'b1; end
        default: ;
      endcase
    end
    condLevel   = lvl;
    useInternal = ~anyEn;
  end

  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      unique case (outMode[i])
        MODE_HIGH: begin gpioOe[i] = 1'b1; gpioOut[i] = strb.pulseOn;  end
        MODE_LOW:  begin gpioOe[i] = 1'b1; gpioOut[i] = ~strb.pulseOn; end
        default:   begin gpioOe[i] = 1'b0; gpioOut[i] = 1'b0;          end
      endcase
    end
  end

  assign sensorTrig = strb.trigStrobe;

  generate
    for (genvar g = 0; g < PINS; g++) begin : g_pinChk
      assert_keep_cond_R3: assert property (@(posedge clk) disable iff (!rstN)
        (condWr && regWdata[2*g +: 2] == MODE_KEEP) |=> $stable(condMode[g]));
      assert_off_pin_R7: assert property (@(posedge clk) disable iff (!rstN)
        (outWr && regWdata[2*g +: 2] == MODE_OFF) |=> (!gpioOe[g] && !gpioOut[g]));
    end
  endgenerate

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_seq_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BL_W     = 8,
  parameter int MIN_FREE = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             condLevel,
  input  logic             useInternal,
  input  logic [CNT_W-1:0] delayVal,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [BL_W-1:0]  bitLenVal,
  input  logic             periodWr,
  output ctrlStrobe_t      strb
);

  localparam int WID_W = BL_W + 4;

  logic             running;
  logic [CNT_W-1:0] perCnt;
  logic             pulseOn;
  logic [WID_W-1:0] widCnt;
  logic [WID_W-1:0] widLoad;
  logic             condPrev;
  logic             busy;
  logic [CNT_W-1:0] dlyCnt;
  logic             trigStrobe;
  logic             isSingle;
  logic             isFree;
  logic             startNow;
  logic             trigEvent;

  assign isSingle = (periodVal == CNT_W'(1));
  assign isFree   = (periodVal >= CNT_W'(MIN_FREE));
  assign widLoad  = {({1'b0, bitLenVal} + (BL_W+1)'(1)), 3'b000} - WID_W'(1);

  always_comb begin
    if (periodWr) startNow = isFree || (isSingle && !pulseOn);
    else          startNow = running && (perCnt == '0);
  end

  assign trigEvent = useInternal ? startNow : (condLevel && !condPrev);

  // period generator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      perCnt  <= '0;
    end else if (periodWr) begin
      running <= isFree;
      perCnt  <= periodVal - CNT_W'(1);
    end else if (running) begin
      perCnt <= (perCnt == '0) ? periodVal - CNT_W'(1) : perCnt - CNT_W'(1);
    end
  end

  // pulse width
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseOn <= 1'b0;
      widCnt  <= '0;
    end else if (startNow) begin
      pulseOn <= 1'b1;
      widCnt  <= widLoad;
    end else if (pulseOn) begin
      if (widCnt == '0) pulseOn <= 1'b0;
      else              widCnt  <= widCnt - WID_W'(1);
    end
  end

  // event detect and delay countdown
  always_ff @(posedge clk) begin
    if (!rstN) begin
      condPrev   <= 1'b1;
      busy       <= 1'b0;
      dlyCnt     <= '0;
      trigStrobe <= 1'b0;
    end else begin
      condPrev   <= condLevel;
      trigStrobe <= 1'b0;
      if (busy) begin
        if (dlyCnt == '0) begin
          trigStrobe <= 1'b1;
          busy       <= 1'b0;
        end else begin
          dlyCnt <= dlyCnt - CNT_W'(1);
        end
      end else if (trigEvent) begin
        if (delayVal == '0) begin
          trigStrobe <= 1'b1;
        end else begin
          busy   <= 1'b1;
          dlyCnt <= delayVal - CNT_W'(1);
        end
      end
    end
  end

  assign strb.pulseOn    = pulseOn;
  assign strb.trigStrobe = trigStrobe;

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    trigStrobe |=> !trigStrobe);
  assert_pulse_min_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOn) |=> pulseOn);
  assert_illegal_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (periodWr && !isFree) |=> !running);
  assert_busy_no_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dlyCnt != '0) |=> (!trigStrobe && busy));

endmodule

// File: rtl/cam_trig_seq.sv
module cam_trig_seq
  import trig_seq_pkg::*;
#(
  parameter int PINS        = 10,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int BL_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_FREE    = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [PINS-1:0]   gpioIn,
  output logic [PINS-1:0]   gpioOut,
  output logic [PINS-1:0]   gpioOe,
  output logic              sensorTrig
);

  ctrlStrobe_t      strb;
  logic             condLevel;
  logic             useInternal;
  logic [CNT_W-1:0] delayVal;
  logic [CNT_W-1:0] periodVal;
  logic [BL_W-1:0]  bitLenVal;
  logic             periodWr;

  trig_datapath #(
    .PINS(PINS), .DATA_W(DATA_W), .CNT_W(CNT_W), .BL_W(BL_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .regWe       (regWe),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .gpioIn      (gpioIn),
    .strb        (strb),
    .gpioOut     (gpioOut),
    .gpioOe      (gpioOe),
    .sensorTrig  (sensorTrig),
    .condLevel   (condLevel),
    .useInternal (useInternal),
    .delayVal    (delayVal),
    .periodVal   (periodVal),
    .bitLenVal   (bitLenVal),
    .periodWr    (periodWr)
  );

  trig_ctrl #(
    .CNT_W(CNT_W), .BL_W(BL_W), .MIN_FREE(MIN_FREE)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .condLevel   (condLevel),
    .useInternal (useInternal),
    .delayVal    (delayVal),
    .periodVal   (periodVal),
    .bitLenVal   (bitLenVal),
    .periodWr    (periodWr),
    .strb        (strb)
  );

endmodule

// File: tb/test_cam_trig_seq.sv
module test_cam_trig_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [9:0]  gpioIn = '0;
  logic [9:0]  gpioOut;
  logic [9:0]  gpioOe;
  logic        sensorTrig;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int expQ[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cam_trig_seq i_cam_trig_seq (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .gpioIn(gpioIn), .gpioOut(gpioOut), .gpioOe(gpioOe), .sensorTrig(sensorTrig)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d, output int w);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    w = cyc;
    regWe = 1'b0;
  endtask

  task automatic setPin(input int p, input bit v, output int c);
    @(negedge clk);
    gpioIn[p] = v;
    c = cyc;
  endtask

  task automatic waitCyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // scoreboard monitor: every strobe must match the next predicted cycle
  always @(negedge clk) begin
    if (rstN && sensorTrig) begin
      if (expQ.size() == 0) check(1'b0, "R5/R6 unexpected strobe", cyc, -1);
      else begin
        int e;
        e = expQ.pop_front();
        check(e == cyc, "R5 strobe cycle", cyc, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int w, c, w2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sensorTrig == 0, "R1 strobe", sensorTrig, 0);
    check(gpioOe == 0, "R1 oe", gpioOe, 0);
    check(gpioOut == 0, "R1 out", gpioOut, 0);
    repeat (20) @(negedge clk);

    // R2 active-high pin 3, delay 5
    writeReg(3'd1, 32'd5, w);
    writeReg(3'd0, 32'h3 << 6, w);
    repeat (4) @(negedge clk);
    setPin(3, 1, c); expQ.push_back(c + 3 + 5);
    repeat (30) @(negedge clk);          // held level, no second strobe (R2)
    setPin(3, 0, c); repeat (4) @(negedge clk);
    setPin(3, 1, c); expQ.push_back(c + 3 + 5);
    repeat (20) @(negedge clk);

    // R2/R3 active-low pin 5, pin 3 kept by code 01
    setPin(5, 1, c); repeat (4) @(negedge clk);
    writeReg(3'd0, (32'h1 << 6) | (32'h2 << 10), w);
    repeat (4) @(negedge clk);
    setPin(3, 0, c); repeat (4) @(negedge clk);
    setPin(3, 1, c); repeat (12) @(negedge clk);   // pin5 high blocks the match
    setPin(5, 0, c); expQ.push_back(c + 3 + 5);    // R2 active-low match
    repeat (15) @(negedge clk);
    setPin(3, 0, c); repeat (4) @(negedge clk);
    setPin(3, 1, c); expQ.push_back(c + 3 + 5);    // R3 pin3 still high-active
    repeat (15) @(negedge clk);

    // R6 event during countdown dropped
    writeReg(3'd0, 32'h3 << 6, w);
    writeReg(3'd1, 32'd20, w);
    repeat (4) @(negedge clk);
    setPin(3, 0, c); repeat (2) @(negedge clk);
    setPin(3, 1, c); expQ.push_back(c + 3 + 20);
    repeat (2) @(negedge clk);
    setPin(3, 0, c); repeat (2) @(negedge clk);
    setPin(3, 1, c);                               // R6 ignored
    repeat (40) @(negedge clk);
    check(expQ.size() == 0, "R6 queue drained", expQ.size(), 0);

    // R5 delay 0
    writeReg(3'd1, 32'd0, w);
    setPin(3, 0, c); repeat (3) @(negedge clk);
    setPin(3, 1, c); expQ.push_back(c + 3);
    repeat (10) @(negedge clk);

    // R7 output select, R4 internal source, R8 single, R11 width 24
    writeReg(3'd2, 32'h3 | (32'h2 << 2), w);
    @(negedge clk);
    check(gpioOe == 10'h003, "R7 oe", gpioOe, 10'h003);
    check(gpioOut == 10'h002, "R7 idle out", gpioOut, 10'h002);
    writeReg(3'd0, 32'h0, w);
    writeReg(3'd1, 32'd2, w);
    writeReg(3'd4, 32'd2, w);
    writeReg(3'd3, 32'd1, w);
    expQ.push_back(w + 1 + 2);                     // R4 internal trigger
    waitCyc(w + 1);
    check(gpioOut == 10'h001, "R8 single pulse on", gpioOut, 10'h001);
    waitCyc(w + 5);
    writeReg(3'd3, 32'd1, w2);                     // R8 no second pulse
    waitCyc(w + 24);
    check(gpioOut == 10'h001, "R11 width end", gpioOut, 10'h001);
    waitCyc(w + 25);
    check(gpioOut == 10'h002, "R8/R11 pulse off", gpioOut, 10'h002);
    repeat (60) @(negedge clk);
    check(gpioOut == 10'h002, "R8 no requeue", gpioOut, 10'h002);

    // R9 free running 256, width 32
    writeReg(3'd1, 32'd0, w);
    writeReg(3'd4, 32'd3, w);
    writeReg(3'd3, 32'd256, w);
    expQ.push_back(w + 1); expQ.push_back(w + 257); expQ.push_back(w + 513);
    waitCyc(w + 1);   check(gpioOut == 10'h001, "R9 first pulse", gpioOut, 10'h001);
    waitCyc(w + 32);  check(gpioOut == 10'h001, "R11 width 32 end", gpioOut, 10'h001);
    waitCyc(w + 33);  check(gpioOut == 10'h002, "R11 width 32 off", gpioOut, 10'h002);
    waitCyc(w + 256); check(gpioOut == 10'h002, "R9 before period", gpioOut, 10'h002);
    waitCyc(w + 257); check(gpioOut == 10'h001, "R9 second pulse", gpioOut, 10'h001);
    waitCyc(w + 520);
    writeReg(3'd3, 32'd0, w2);                     // R10 stop
    waitCyc(w2 + 600);
    check(gpioOut == 10'h002, "R10 stopped", gpioOut, 10'h002);
    check(expQ.size() == 0, "R10 no extra pulses", expQ.size(), 0);

    // R9 restart on rewrite
    writeReg(3'd3, 32'd256, w);
    expQ.push_back(w + 1);
    waitCyc(w + 100);
    writeReg(3'd3, 32'd256, w2);
    expQ.push_back(w2 + 1); expQ.push_back(w2 + 257);
    waitCyc(w + 257);
    check(gpioOut == 10'h002, "R9 old schedule dropped", gpioOut, 10'h002);
    waitCyc(w2 + 257);
    check(gpioOut == 10'h001, "R9 restarted pulse", gpioOut, 10'h001);
    waitCyc(w2 + 260);
    writeReg(3'd3, 32'd0, w);

    // R10 illegal short period
    writeReg(3'd3, 32'd100, w);
    waitCyc(w + 400);
    check(gpioOut == 10'h002, "R10 short period idle", gpioOut, 10'h002);
    check(expQ.size() == 0, "R10 queue empty", expQ.size(), 0);

    // R3 keep on output select
    writeReg(3'd2, 32'h1 | (32'h1 << 2) | (32'h3 << 4), w);
    @(negedge clk);
    check(gpioOe == 10'h007, "R3 outsel keep", gpioOe, 10'h007);
    check(gpioOut == 10'h002, "R3/R7 outsel levels", gpioOut, 10'h002);

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R5 all strobes seen", expQ.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule